// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block decides whether a store-exclusive may complete. Each processing element (PE) has a private local monitor, and the PEs share one global monitor. A load-exclusive records a reservation in the local monitor of the PE that issued it. If the access is shareable, it also records a reservation of one 64-byte granule in the global monitor, tagged with that PE.

A store-exclusive with the same fields is checked in two stages. First the local monitor must hold a reservation that covers every byte of the requested region. When the access is shareable, the global entry of that PE must then still cover the granule. Every store-exclusive check empties the local monitor of its PE. Plain stores, and store-exclusives that succeed, remove the global reservations that other PEs hold on the same granule. A store-exclusive whose address is not a multiple of its size reports an alignment fault and never succeeds. The status bit uses the usual retry convention: 0 lets the write go ahead and 1 suppresses it, so software repeats the loop.

The block takes one request per cycle and is always ready. The result of a store-exclusive is registered and appears one cycle after the request.

Top module: `excl_monitor_top`

## Requirements
- R1: After reset no PE holds a local or global reservation, all outputs are 0, and a store-exclusive issued before any load-exclusive returns status 1.
- R2: `req_op` encodes 0 = no operation, 1 = plain store, 2 = load-exclusive, 3 = store-exclusive. A store-exclusive accepted in cycle N produces `rsp_valid` = 1 in cycle N+1, with status 0 for success and 1 for failure. Other operations produce no response.
- R3: `req_size` encodes 0/1/2/3 = 1/2/4/8 bytes. A store-exclusive whose address is not a multiple of its byte count returns `rsp_fault` = 1 and status 1.
- R4: A load-exclusive replaces the PE's local reservation with its address and size. The local stage passes only if the reserved byte range contains the whole requested range. For example, an 8-byte reservation at 0x100 covers 4 bytes at 0x104 but not 4 bytes at 0x108.
- R5: Every store-exclusive check empties the requesting PE's local monitor, whether the check passes, fails or faults.
- R6: For a shareable store-exclusive that passes the local stage, success also requires a global entry for that PE holding the same 64-byte granule (address bits above bit 5).
- R7: A non-shareable store-exclusive that passes the local stage succeeds without consulting the global monitor.
- R8: A plain store to a granule removes the global reservations of every other PE on that granule. It leaves the storing PE's own entry, entries on other granules, and all local monitors unchanged.
- R9: A successful store-exclusive removes the other PEs' global reservations on its granule. A failed one removes none.
- R10: Pulsing `clrex[p]` empties the local monitor of PE p and leaves the global monitor intact. If it coincides with a load-exclusive from p, the clear wins.
- R11: Reservations of different PEs are independent: a load-exclusive from one PE does not alter another PE's local monitor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (see R2) |
| req_pe | input | 2 | Requesting PE index |
| req_addr | input | 32 | Physical byte address |
| req_size | input | 2 | Log2 of access size in bytes |
| req_shared | input | 1 | Access is shareable |
| clrex | input | 4 | Per-PE local monitor clear |
| rsp_valid | output | 1 | Store-exclusive result present |
| rsp_status | output | 1 | 0 = success, 1 = failure |
| rsp_fault | output | 1 | Alignment fault on the store-exclusive |

## Verification
The properties assume that `req_pe` names an existing PE and that inputs hold known values once reset is released. They also assume that a plain store is naturally aligned, so that it touches only one granule. The stimulus issues one request per cycle from a task that writes only legal PE indices and aligned plain stores. Misalignment is applied only to store-exclusives, where it is the behaviour under test.

// File: rtl/excl_mon_pkg.sv
// Package: shared operation encoding for the exclusive reservation monitor.
// Assumes a two-bit operation field on the request.
package excl_mon_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_STORE = 2'd1,
        OP_LDEX  = 2'd2,
        OP_STEX  = 2'd3
    } excl_op_e;

endpackage

// File: rtl/excl_local_mon.sv
// Module: one PE's local reservation. It holds an address and a size code,
// and reports whether a queried byte range lies inside the held range.
// Assumes the clear and set strobes come from the same PE; clear wins.
module excl_local_mon #(
    parameter int AW  = 32,
    parameter int SZW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_en,
    input  logic           clr_en,
    input  logic [AW-1:0]  set_addr,
    input  logic [SZW-1:0] set_size,
    input  logic [AW-1:0]  chk_addr,
    input  logic [SZW-1:0] chk_size,
    output logic           vld,
    output logic           covers
);
    localparam int EW = AW + 1;

    logic [AW-1:0]  res_addr;
    logic [SZW-1:0] res_size;
    logic [EW-1:0]  res_lo, res_hi, q_lo, q_hi;

    // Hold or replace the reservation; a clear takes priority over a set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld      <= 1'b0;
            res_addr <= '0;
            res_size <= '0;
        end else if (clr_en) begin
            vld <= 1'b0;
        end else if (set_en) begin
            vld      <= 1'b1;
            res_addr <= set_addr;
            res_size <= set_size;
        end
    end

    // Containment test on end-exclusive byte ranges with one guard bit.
    always_comb begin
        res_lo = {1'b0, res_addr};
        res_hi = res_lo + (EW'(1) << res_size);
        q_lo   = {1'b0, chk_addr};
        q_hi   = q_lo + (EW'(1) << chk_size);
        covers = vld && (q_lo >= res_lo) && (q_hi <= res_hi);
    end
endmodule

// File: rtl/excl_global_mon.sv
// Module: shared global monitor, one granule entry per PE.
// Assumes at most one of set or kill is active per cycle (one request per cycle).
module excl_global_mon #(
    parameter int NPE = 4,
    parameter int GW  = 26
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_en,
    input  logic [$clog2(NPE)-1:0] set_pe,
    input  logic [GW-1:0]          set_gran,
    input  logic                   kill_en,
    input  logic [$clog2(NPE)-1:0] kill_pe,
    input  logic [GW-1:0]          kill_gran,
    input  logic [$clog2(NPE)-1:0] chk_pe,
    input  logic [GW-1:0]          chk_gran,
    output logic                   hit
);
    logic [NPE-1:0] ent_vld;
    logic [GW-1:0]  ent_gran [NPE];

    for (genvar p = 0; p < NPE; p++) begin : g_ent
        // Update entry p: its own load-exclusive sets it, other PEs' writes to the granule clear it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vld[p]  <= 1'b0;
                ent_gran[p] <= '0;
            end else if (set_en && (set_pe == p)) begin
                ent_vld[p]  <= 1'b1;
                ent_gran[p] <= set_gran;
            end else if (kill_en && (kill_pe != p) && (ent_gran[p] == kill_gran)) begin
                ent_vld[p] <= 1'b0;
            end
        end
    end

    // Look up the requesting PE's entry.
    always_comb hit = ent_vld[chk_pe] && (ent_gran[chk_pe] == chk_gran);
endmodule

// File: rtl/excl_monitor_top.sv
// Module: exclusive reservation monitor top. It combines the per-PE local
// monitors with the global monitor and registers the store-exclusive result.
// Assumes one request per cycle and req_pe < NPE.
module excl_monitor_top
    import excl_mon_pkg::*;
#(
    parameter int NPE     = 4,
    parameter int AW      = 32,
    parameter int SZW     = 2,
    parameter int GRAN_LG = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             req_op,
    input  logic [$clog2(NPE)-1:0] req_pe,
    input  logic [AW-1:0]          req_addr,
    input  logic [SZW-1:0]         req_size,
    input  logic                   req_shared,
    input  logic [NPE-1:0]         clrex,
    output logic                   rsp_valid,
    output logic                   rsp_status,
    output logic                   rsp_fault
);
    localparam int GW = AW - GRAN_LG;

    logic           is_st, is_ldx, is_stx;
    logic           aligned, glb_hit, pass;
    logic [AW-1:0]  size_mask;
    logic [GW-1:0]  gran;
    logic [NPE-1:0] loc_vld, loc_cov;

    // Decode the request and form the alignment and granule terms.
    always_comb begin
        is_st     = req_valid && (req_op == OP_STORE);
        is_ldx    = req_valid && (req_op == OP_LDEX);
        is_stx    = req_valid && (req_op == OP_STEX);
        size_mask = (AW'(1) << req_size) - AW'(1);
        aligned   = (req_addr & size_mask) == '0;
        gran      = req_addr[AW-1:GRAN_LG];
    end

    for (genvar p = 0; p < NPE; p++) begin : g_loc
        excl_local_mon #(.AW(AW), .SZW(SZW)) i_loc (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_en   (is_ldx && (req_pe == p)),
            .clr_en   (clrex[p] || (is_stx && (req_pe == p))),
            .set_addr (req_addr),
            .set_size (req_size),
            .chk_addr (req_addr),
            .chk_size (req_size),
            .vld      (loc_vld[p]),
            .covers   (loc_cov[p])
        );
    end

    // Two-stage decision: local coverage, then global only when shareable.
    always_comb pass = aligned && loc_cov[req_pe] && (!req_shared || glb_hit);

    excl_global_mon #(.NPE(NPE), .GW(GW)) i_glb (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (is_ldx && req_shared),
        .set_pe    (req_pe),
        .set_gran  (gran),
        .kill_en   (is_st || (is_stx && pass)),
        .kill_pe   (req_pe),
        .kill_gran (gran),
        .chk_pe    (req_pe),
        .chk_gran  (gran),
        .hit       (glb_hit)
    );

    // Register the store-exclusive result for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_status <= 1'b0;
            rsp_fault  <= 1'b0;
        end else begin
            rsp_valid  <= is_stx;
            rsp_status <= is_stx && !pass;
            rsp_fault  <= is_stx && !aligned;
        end
    end
endmodule

// File: rtl/excl_mon_checker.sv
// Module: property checker for excl_monitor_top, attached with bind.
// Assumes req_pe < NPE and known inputs after reset.
module excl_mon_checker #(
    parameter int NPE = 4,
    parameter int AW  = 32,
    parameter int SZW = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic [1:0]             req_op,
    input logic [$clog2(NPE)-1:0] req_pe,
    input logic [AW-1:0]          req_addr,
    input logic [SZW-1:0]         req_size,
    input logic [NPE-1:0]         clrex,
    input logic [NPE-1:0]         loc_vld,
    input logic                   rsp_valid,
    input logic                   rsp_status,
    input logic                   rsp_fault
);
    logic stx, misal;
    // Observe store-exclusive requests and whether their address breaks alignment.
    always_comb begin
        stx   = req_valid && (req_op == 2'd3);
        misal = (req_addr % (AW'(1) << req_size)) != '0;
    end

    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n) stx |=> rsp_valid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n) !stx |=> !rsp_valid);
    p_fault_raised_r3: assert property (@(posedge clk) disable iff (!rst_n) (stx && misal) |=> rsp_fault);
    p_fault_fails_r3: assert property (@(posedge clk) disable iff (!rst_n) rsp_fault |-> rsp_status);
    p_open_fails_r1: assert property (@(posedge clk) disable iff (!rst_n) (stx && !loc_vld[req_pe]) |=> rsp_status);

    for (genvar p = 0; p < NPE; p++) begin : g_pe
        p_check_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (stx && (req_pe == p)) |=> !loc_vld[p]);
        p_clrex_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
            clrex[p] |=> !loc_vld[p]);
    end
endmodule

bind excl_monitor_top excl_mon_checker #(.NPE(NPE), .AW(AW), .SZW(SZW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_pe     (req_pe),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .clrex      (clrex),
    .loc_vld    (loc_vld),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_fault  (rsp_fault)
);

// File: tb/test_excl_monitor_top.sv
// Bench: a scoreboard queue holds the expected store-exclusive results and a
// negedge monitor compares them against the responses.
module test_excl_monitor_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [1:0]  req_pe = 2'd0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = 2'd0;
    logic        req_shared = 1'b0;
    logic [3:0]  clrex = '0;
    logic        rsp_valid, rsp_status, rsp_fault;

    typedef struct {
        logic  status;
        logic  fault;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    excl_monitor_top i_excl_monitor_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_pe(req_pe), .req_addr(req_addr), .req_size(req_size),
        .req_shared(req_shared), .clrex(clrex), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_fault(rsp_fault)
    );

    // Drive one request for one cycle, starting on a falling edge.
    task automatic drive(input logic [1:0] op, input int pe, input logic [31:0] a,
                         input logic [1:0] sz, input logic sh);
        req_valid = 1'b1; req_op = op; req_pe = 2'(pe);
        req_addr = a; req_size = sz; req_shared = sh;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'd0;
    endtask

    task automatic ldex(input int pe, input logic [31:0] a, input logic [1:0] sz, input logic sh);
        drive(2'd2, pe, a, sz, sh);
    endtask

    task automatic store(input int pe, input logic [31:0] a, input logic [1:0] sz);
        drive(2'd1, pe, a, sz, 1'b0);
    endtask

    // Queue the expected result, then issue the store-exclusive.
    task automatic stex(input int pe, input logic [31:0] a, input logic [1:0] sz, input logic sh,
                        input logic st, input logic ft, input string tag);
        exp_t e;
        e.status = st; e.fault = ft; e.tag = tag;
        exp_q.push_back(e);
        drive(2'd3, pe, a, sz, sh);
    endtask

    task automatic pulse_clrex(input int pe);
        clrex[pe] = 1'b1;
        @(negedge clk);
        clrex = '0;
    endtask

    // Compare every response against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2 response without store-exclusive: status=%0b expected no response", rsp_status);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_status !== e.status || rsp_fault !== e.fault) begin
                    n_fail++;
                    $display("FAIL %s status=%0b fault=%0b expected status=%0b fault=%0b",
                             e.tag, rsp_status, rsp_fault, e.status, e.fault);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0 || rsp_status !== 1'b0 || rsp_fault !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset outputs=%0b%0b%0b expected 000", rsp_valid, rsp_status, rsp_fault);
        end
        rst_n = 1'b1;
        @(negedge clk);

        stex(0, 32'h100, 2'd3, 1'b0, 1'b1, 1'b0, "R1 store-exclusive before any reservation");

        ldex(0, 32'h100, 2'd3, 1'b0);
        stex(0, 32'h104, 2'd2, 1'b0, 1'b0, 1'b0, "R4 covered sub-range");
        stex(0, 32'h104, 2'd2, 1'b0, 1'b1, 1'b0, "R5 local cleared after pass");
        ldex(0, 32'h100, 2'd3, 1'b0);
        stex(0, 32'h108, 2'd2, 1'b0, 1'b1, 1'b0, "R4 range beyond reservation");
        ldex(0, 32'h100, 2'd2, 1'b0);
        ldex(0, 32'h200, 2'd3, 1'b0);
        stex(0, 32'h100, 2'd2, 1'b0, 1'b1, 1'b0, "R4 replaced reservation");
        stex(0, 32'h200, 2'd3, 1'b0, 1'b1, 1'b0, "R5 local cleared after fail");

        ldex(1, 32'h40, 2'd3, 1'b0);
        stex(1, 32'h42, 2'd2, 1'b0, 1'b1, 1'b1, "R3 misaligned word");
        stex(1, 32'h40, 2'd3, 1'b0, 1'b1, 1'b0, "R5 local cleared after fault");
        ldex(2, 32'hD01, 2'd0, 1'b0);
        stex(2, 32'hD01, 2'd0, 1'b0, 1'b0, 1'b0, "R4 single byte at odd address");
        ldex(2, 32'hD01, 2'd1, 1'b0);
        stex(2, 32'hD01, 2'd1, 1'b0, 1'b1, 1'b1, "R3 misaligned halfword");

        ldex(2, 32'h300, 2'd3, 1'b1);
        stex(2, 32'h300, 2'd3, 1'b1, 1'b0, 1'b0, "R6 shareable with global entry");
        ldex(3, 32'h400, 2'd3, 1'b0);
        stex(3, 32'h400, 2'd3, 1'b1, 1'b1, 1'b0, "R6 shareable without global entry");
        ldex(3, 32'h500, 2'd3, 1'b0);
        stex(3, 32'h500, 2'd3, 1'b0, 1'b0, 1'b0, "R7 non-shareable skips global");

        ldex(0, 32'h600, 2'd3, 1'b1);
        store(1, 32'h638, 2'd3);
        stex(0, 32'h600, 2'd3, 1'b1, 1'b1, 1'b0, "R8 store by other PE in granule");
        ldex(0, 32'h600, 2'd3, 1'b1);
        store(1, 32'h640, 2'd3);
        store(0, 32'h600, 2'd3);
        stex(0, 32'h600, 2'd3, 1'b1, 1'b0, 1'b0, "R8 other granule and own store keep entry");

        ldex(1, 32'h700, 2'd3, 1'b1);
        ldex(2, 32'h710, 2'd2, 1'b1);
        stex(1, 32'h700, 2'd3, 1'b1, 1'b0, 1'b0, "R9 first store-exclusive wins");
        stex(2, 32'h710, 2'd2, 1'b1, 1'b1, 1'b0, "R9 loser cleared by winner");
        ldex(2, 32'h800, 2'd3, 1'b1);
        stex(1, 32'h800, 2'd3, 1'b1, 1'b1, 1'b0, "R9 failing store-exclusive");
        stex(2, 32'h800, 2'd3, 1'b1, 1'b0, 1'b0, "R9 failed store-exclusive clears nothing");

        ldex(3, 32'hA00, 2'd3, 1'b1);
        pulse_clrex(3);
        stex(3, 32'hA00, 2'd3, 1'b1, 1'b1, 1'b0, "R10 clear empties local");
        ldex(3, 32'hA00, 2'd3, 1'b0);
        stex(3, 32'hA00, 2'd3, 1'b1, 1'b0, 1'b0, "R10 clear keeps global");

        ldex(0, 32'hB00, 2'd3, 1'b0);
        ldex(1, 32'hC00, 2'd3, 1'b0);
        stex(0, 32'hB00, 2'd3, 1'b0, 1'b0, 1'b0, "R11 PE0 unaffected by PE1");
        stex(1, 32'hC00, 2'd3, 1'b0, 1'b0, 1'b0, "R11 PE1 reservation intact");

        repeat (3) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 missing responses: %0d outstanding expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule